// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block lets a clocked host read and write an external asynchronous static RAM that holds 131072 bytes (17-bit address, 8-bit data). The host raises a request with a direction flag, an address and write data while `ready` is high. The controller then sequences the memory's active-low chip select, output enable and write strobe through a set of phases. Each phase lasts a whole number of clock cycles, derived at elaboration from nanosecond parameters and the clock period, always rounded up. When the access finishes it returns a one-cycle acknowledge and, for reads, the captured byte.

The memory data pins are shared and bidirectional. The controller drives them through a separate output value and drive-enable pair, and the pad ring turns these into the tri-state bus. Between accesses the chip select is held high, so the memory sits in low-power standby with its pins released. A write is bounded by the overlap of chip select and write strobe. Both rise together at write end. The controller drives data only in the last part of the strobe, after a turnaround allowance for the memory's own drivers to switch off, so the data-setup interval before the ending edge is always honoured.

A parameter chooses whether output enable stays asserted during writes. That choice sets the minimum strobe width used and the turnaround allowance.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is applied and after its release, mem_ce_n, mem_oe_n and mem_we_n are 1, mem_dq_oe is 0, ack is 0, rdata is 0 and ready is 1.
- R2: Whenever no access is in progress (ready is 1), mem_ce_n is 1.
- R3: A read (wr=0) holds one address-setup cycle with mem_ce_n=1, then mem_ce_n=0 and mem_oe_n=0 with mem_we_n=1 for RD_CYC cycles (2 at defaults). The byte on mem_dq_i at the end of the last of these cycles appears on rdata with the ack pulse. rdata keeps that value until the next read completes, including across writes.
- R4: A write (wr=1) holds mem_ce_n=0 and mem_we_n=0 together, and both rise on the same edge. The byte stored at write end equals wdata sampled when the request was accepted.
- R5: mem_dq_oe is 1 only while mem_we_n is 0. It first rises after TA_CYC cycles of mem_we_n low (1 at defaults) and stays 1 for DRV_CYC cycles (1 at defaults) up to write end. mem_dq_o is constant while it is 1, and it is never 1 while the memory is enabled to drive.
- R6: mem_addr is loaded when a request is accepted and does not change while mem_ce_n is 0.
- R7: ack is high for exactly one cycle per accepted request, and ready is 0 from acceptance until that ack. A request raised while ready is 0 is ignored and causes no access or ack.
- R8: With the default policy (output enable high during writes), mem_oe_n is 1 whenever mem_we_n is 0. The strobe stays low for the larger of the write-cycle count and the strobe-width count for that policy (2 cycles at defaults).
- R9: Every 17-bit address, including 0x00000 and 0x1FFFF, reaches mem_addr unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req | input | 1 | Access request, accepted on a clock edge where ready is 1 |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 17 | Byte address |
| wdata | input | 8 | Write data |
| ready | output | 1 | Controller idle and able to accept a request |
| ack | output | 1 | One-cycle completion pulse |
| rdata | output | 8 | Last byte read, valid from its ack until the next read |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_we_n | output | 1 | Memory write strobe, active low |
| mem_dq_o | output | 8 | Data value for the pad drivers |
| mem_dq_oe | output | 1 | Pad driver enable for the data pins |
| mem_dq_i | input | 8 | Data value seen on the pins |

## Verification
The hardest case to reach from the ports is a request that arrives while an access is still under way. It must be ignored without corrupting the address or data of the access in flight. The stimulus raises a read, then keeps req high with a different address and data for two more cycles, and drops it just before the acknowledge. The scoreboard then requires the read to return the original location's byte, requires no further acknowledge, and requires an empty queue. A memory model on the pins tracks every strobe cycle. This lets the scoreboard measure strobe length, driver window, bus contention and address stability on each access, across boundary addresses and a random mix of reads and writes.

// File: rtl/asram_pkg.sv
`timescale 1ns/1ps
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_RACC  = 3'd2,
    ST_WTA   = 3'd3,
    ST_WDRV  = 3'd4
  } asram_ph_e;

  // cycles needed to cover ns at a given clock period, rounded up
  function automatic int cyc_of(input int ns, input int clk_ns);
    return (ns + clk_ns - 1) / clk_ns;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_phase_timer.sv
`timescale 1ns/1ps
module asram_phase_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] ld_val,
  output logic          done
);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  assign cnt_en = load | (cnt_q != '0);

  always_comb begin
    if (load) cnt_d = ld_val;
    else      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign done = (cnt_q == '0);

endmodule

// File: rtl/asram_rdcap.sv
`timescale 1ns/1ps
module asram_rdcap #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cap_en,
  input  logic [DW-1:0] din,
  output logic [DW-1:0] rdata
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rdata <= '0;
    else if (cap_en) rdata <= din;
  end

endmodule

// File: rtl/asram_seq.sv
`timescale 1ns/1ps
module asram_seq
  import asram_pkg::*;
#(
  parameter int AW           = 17,
  parameter int DW           = 8,
  parameter int CW           = 2,
  parameter int RD_CYC       = 2,
  parameter int TA_CYC       = 1,
  parameter int DRV_CYC      = 1,
  parameter bit OE_LOW_ON_WR = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          tmr_done,
  output logic          tmr_load,
  output logic [CW-1:0] tmr_val,
  output logic          ready,
  output logic          ack,
  output logic          cap_en,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] dq_o,
  output logic          dq_oe
);

  asram_ph_e state_q, state_d;
  logic      take;
  logic      finish;
  logic      wr_q;
  logic      ce_n_d, oe_n_d, we_n_d, oe_d;

  // next-state logic
  always_comb begin
    state_d  = state_q;
    tmr_load = 1'b0;
    tmr_val  = '0;
    take     = 1'b0;
    case (state_q)
      ST_IDLE: begin
        if (req) begin
          take    = 1'b1;
          state_d = ST_SETUP;
        end
      end
      ST_SETUP: begin
        tmr_load = 1'b1;
        if (wr_q) begin
          state_d = ST_WTA;
          tmr_val = CW'(TA_CYC - 1);
        end else begin
          state_d = ST_RACC;
          tmr_val = CW'(RD_CYC - 1);
        end
      end
      ST_RACC: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      ST_WTA: begin
        if (tmr_done) begin
          state_d  = ST_WDRV;
          tmr_load = 1'b1;
          tmr_val  = CW'(DRV_CYC - 1);
        end
      end
      ST_WDRV: begin
        if (tmr_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  assign finish = ((state_q == ST_RACC) || (state_q == ST_WDRV)) && tmr_done;
  assign cap_en = (state_q == ST_RACC) && tmr_done;
  assign ready  = (state_q == ST_IDLE);

  // memory pin levels for the coming cycle
  always_comb begin
    ce_n_d = !((state_d == ST_RACC) || (state_d == ST_WTA) || (state_d == ST_WDRV));
    we_n_d = !((state_d == ST_WTA) || (state_d == ST_WDRV));
    oe_n_d = !((state_d == ST_RACC) ||
               (OE_LOW_ON_WR && ((state_d == ST_WTA) || (state_d == ST_WDRV))));
    oe_d   = (state_d == ST_WDRV);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q  <= ST_IDLE;
      mem_ce_n <= 1'b1;
      mem_oe_n <= 1'b1;
      mem_we_n <= 1'b1;
      dq_oe    <= 1'b0;
      ack      <= 1'b0;
    end else begin
      state_q  <= state_d;
      mem_ce_n <= ce_n_d;
      mem_oe_n <= oe_n_d;
      mem_we_n <= we_n_d;
      dq_oe    <= oe_d;
      ack      <= finish;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_addr <= '0;
      wr_q     <= 1'b0;
      dq_o     <= '0;
    end else if (take) begin
      mem_addr <= addr;
      wr_q     <= wr;
      dq_o     <= wdata;
    end
  end

  AST_IDLE_DESELECT: assert property (@(posedge clk) disable iff (!rst_n)
    ready |-> mem_ce_n);                                             // R2
  AST_WE_WITHIN_CE: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> !mem_ce_n);                                        // R4
  AST_DRV_WITHIN_WE: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> !mem_we_n);                                            // R5
  AST_DRV_AFTER_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(dq_oe) |-> $past(!mem_we_n));                              // R5
  AST_WDATA_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_oe && $past(dq_oe)) |-> $stable(dq_o));                      // R5
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_ce_n |-> $stable(mem_addr));                                // R6
  AST_ACK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);                                                   // R7
  AST_OE_OFF_IN_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_we_n && !OE_LOW_ON_WR) |-> mem_oe_n);                      // R8

endmodule

// File: rtl/asram_ctrl.sv
`timescale 1ns/1ps
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int AW            = 17,
  parameter int DW            = 8,
  parameter int CLK_NS        = 5,
  parameter int T_AA_NS       = 10,
  parameter int T_RC_NS       = 10,
  parameter int T_WC_NS       = 10,
  parameter int T_SD_NS       = 5,
  parameter int T_PWE_OEH_NS  = 7,
  parameter int T_PWE_OEL_NS  = 10,
  parameter int T_HZWE_NS     = 5,
  parameter bit OE_LOW_ON_WR  = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic          ready,
  output logic          ack,
  output logic [DW-1:0] rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int RD_CYC  = imax(1, imax(cyc_of(T_AA_NS, CLK_NS), cyc_of(T_RC_NS, CLK_NS)));
  localparam int PWE_CYC = OE_LOW_ON_WR ? cyc_of(T_PWE_OEL_NS, CLK_NS)
                                        : cyc_of(T_PWE_OEH_NS, CLK_NS);
  localparam int TA_CYC  = OE_LOW_ON_WR ? imax(1, cyc_of(T_HZWE_NS, CLK_NS)) : 1;
  localparam int DRV_CYC = imax(1, imax(cyc_of(T_SD_NS, CLK_NS),
                                imax(PWE_CYC - TA_CYC, cyc_of(T_WC_NS, CLK_NS) - TA_CYC)));
  localparam int MAX_CYC = imax(RD_CYC, imax(TA_CYC, DRV_CYC));
  localparam int CW      = imax(1, $clog2(MAX_CYC + 1));

  logic          rst_meta_q, rst_sync_q;
  logic          tmr_load, tmr_done, cap_en;
  logic [CW-1:0] tmr_val;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  asram_phase_timer #(.CW(CW)) u_timer (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .load   (tmr_load),
    .ld_val (tmr_val),
    .done   (tmr_done)
  );

  asram_seq #(
    .AW(AW), .DW(DW), .CW(CW),
    .RD_CYC(RD_CYC), .TA_CYC(TA_CYC), .DRV_CYC(DRV_CYC),
    .OE_LOW_ON_WR(OE_LOW_ON_WR)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .req      (req),
    .wr       (wr),
    .addr     (addr),
    .wdata    (wdata),
    .tmr_done (tmr_done),
    .tmr_load (tmr_load),
    .tmr_val  (tmr_val),
    .ready    (ready),
    .ack      (ack),
    .cap_en   (cap_en),
    .mem_addr (mem_addr),
    .mem_ce_n (mem_ce_n),
    .mem_oe_n (mem_oe_n),
    .mem_we_n (mem_we_n),
    .dq_o     (mem_dq_o),
    .dq_oe    (mem_dq_oe)
  );

  asram_rdcap #(.DW(DW)) u_rdcap (
    .clk    (clk),
    .rst_n  (rst_sync_q),
    .cap_en (cap_en),
    .din    (mem_dq_i),
    .rdata  (rdata)
  );

endmodule

// File: tb/sim_asram_ctrl.sv
`timescale 1ns/1ps
module sim_asram_ctrl;

  localparam int AW      = 17;
  localparam int DW      = 8;
  localparam int EXP_RD  = 2;  // 10 ns at 5 ns, rounded up
  localparam int EXP_WE  = 2;  // max(7 ns, 10 ns write cycle) -> 2 cycles
  localparam int EXP_DRV = 1;  // 5 ns data setup -> 1 cycle

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req, wr;
  logic [AW-1:0] addr;
  logic [DW-1:0] wdata;
  logic          ready, ack;
  logic [DW-1:0] rdata;
  logic [AW-1:0] mem_addr;
  logic          mem_ce_n, mem_oe_n, mem_we_n, mem_dq_oe;
  logic [DW-1:0] mem_dq_o, mem_dq_i;

  always #2.5 clk = ~clk;

  asram_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .ready(ready), .ack(ack), .rdata(rdata), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // memory model on the pins
  logic [DW-1:0] mem_m [int];
  logic [DW-1:0] model_q = '0;
  logic          mem_drv;
  assign mem_drv  = !mem_ce_n && !mem_oe_n && mem_we_n;
  assign mem_dq_i = mem_drv ? model_q : 8'hEE;

  typedef struct { bit w; int a; logic [DW-1:0] d; } item_t;
  item_t         sb_q[$];
  logic [DW-1:0] ref_m [int];

  int  checks = 0, errors = 0, acks = 0, accepted = 0;
  bit  done = 0;

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic access(input bit w, input int a, input logic [DW-1:0] d);
    item_t it;
    while (!ready) begin @(posedge clk); #1; end
    it.w = w; it.a = a;
    if (w) begin it.d = d; ref_m[a] = d; end
    else   it.d = ref_m.exists(a) ? ref_m[a] : 8'h00;
    sb_q.push_back(it);
    accepted++;
    req = 1'b1; wr = w; addr = AW'(a); wdata = d;
    @(posedge clk); #1;
    req = 1'b0;
  endtask

  // monitor and scoreboard
  bit            pend = 0, prev_ce_low = 0, prev_ack = 0;
  int            paddr = 0;
  logic [DW-1:0] pdata = '0, committed = '0, last_rd = '0;
  logic [AW-1:0] prev_addr = '0;
  int            we_cnt = 0, drv_cnt = 0, oe_cnt = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (pend && !(!mem_ce_n && !mem_we_n)) begin
        mem_m[paddr] = pdata; committed = pdata; pend = 0;
      end
      if (!mem_ce_n && !mem_we_n) begin
        pend = 1; paddr = int'(mem_addr); we_cnt++;
        if (mem_dq_oe) begin pdata = mem_dq_o; drv_cnt++; end
        chk(mem_oe_n == 1'b1, "R8 oe during write", int'(mem_oe_n), 1);
      end
      if (!mem_ce_n && !mem_oe_n) begin
        oe_cnt++;
        chk(mem_we_n == 1'b1, "R3 we during read", int'(mem_we_n), 1);
      end
      if (!mem_ce_n) model_q = mem_m.exists(int'(mem_addr)) ? mem_m[int'(mem_addr)] : 8'h00;
      if (ready) chk(mem_ce_n == 1'b1, "R2 idle deselect", int'(mem_ce_n), 1);
      if (mem_dq_oe) begin
        chk(!mem_drv, "R5 bus contention", int'(mem_drv), 0);
        chk(mem_we_n == 1'b0, "R5 drive outside strobe", int'(mem_we_n), 0);
      end
      if (!mem_ce_n && prev_ce_low)
        chk(mem_addr == prev_addr, "R6 addr moved", int'(mem_addr), int'(prev_addr));
      if (!ready && !ack)
        chk(sb_q.size() == 1, "R7 busy without request", sb_q.size(), 1);
      if (ack) begin
        item_t it;
        acks++;
        chk(!prev_ack, "R7 ack width", int'(prev_ack), 0);
        if (sb_q.size() == 0) begin
          chk(1'b0, "R7 unexpected ack", 1, 0);
        end else begin
          it = sb_q.pop_front();
          chk(mem_addr == AW'(it.a), "R9 address", int'(mem_addr), it.a);
          if (it.w) begin
            chk(we_cnt == EXP_WE, "R8 strobe length", we_cnt, EXP_WE);
            chk(drv_cnt == EXP_DRV, "R5 drive length", drv_cnt, EXP_DRV);
            chk(committed == it.d, "R4 stored byte", int'(committed), int'(it.d));
            chk(rdata == last_rd, "R3 rdata hold", int'(rdata), int'(last_rd));
          end else begin
            chk(oe_cnt == EXP_RD, "R3 read window", oe_cnt, EXP_RD);
            chk(we_cnt == 0, "R3 no strobe", we_cnt, 0);
            chk(rdata == it.d, "R3 read data", int'(rdata), int'(it.d));
            last_rd = rdata;
          end
        end
        we_cnt = 0; drv_cnt = 0; oe_cnt = 0;
      end
      prev_ack    = ack;
      prev_ce_low = !mem_ce_n;
      prev_addr   = mem_addr;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL R7 watchdog: actual hung expected completion");
      finish_run();
    end
  end

  initial begin
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes in reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dq_oe && !ack, "R1 drive/ack in reset", {mem_dq_oe, ack}, 0);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes after reset", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(rdata == 8'h00 && ready, "R1 rdata/ready", {ready, rdata}, 9'h100);
    @(posedge clk); #1;

    // boundary addresses and write-then-read
    access(1, 0, 8'h5A);
    access(1, 17'h1FFFF, 8'hA5);
    access(1, 17'h12345, 8'h3C);
    access(0, 17'h1FFFF, 8'h00);
    access(0, 0, 8'h00);
    access(0, 17'h12345, 8'h00);
    access(0, 17'h00777, 8'h00);   // never written
    access(1, 17'h12345, 8'hC3);
    access(0, 17'h12345, 8'h00);

    // request held while busy: must be ignored (R7)
    while (!ready) begin @(posedge clk); #1; end
    begin
      item_t it;
      it.w = 0; it.a = 0; it.d = ref_m[0];
      sb_q.push_back(it); accepted++;
      req = 1'b1; wr = 1'b0; addr = '0;
      @(posedge clk); #1;
      wr = 1'b1; addr = 17'h1FFFF; wdata = 8'hFF;
      @(posedge clk); #1;
      @(posedge clk); #1;
      req = 1'b0;
    end
    repeat (10) @(posedge clk);
    #1;
    chk(sb_q.size() == 0 && acks == accepted, "R7 ignored request", acks, accepted);
    access(0, 17'h1FFFF, 8'h00);

    // random mix over a small pool with spread high bits
    for (int i = 0; i < 60; i++) begin
      int a;
      a = int'($urandom_range(0, 15)) | (int'($urandom_range(0, 3)) << 15);
      access($urandom_range(0, 1) == 1, a, 8'($urandom));
    end

    while (sb_q.size() != 0) @(posedge clk);
    repeat (5) @(posedge clk);
    #1;
    chk(acks == accepted, "R7 ack count", acks, accepted);
    finish_run();
  end

endmodule